// File: doc/BRIEF.md
# Halfword Byte-Swapping DMA Bridge

This bridge links the DMA request port of a peripheral with a 16-bit data bus to a byte-addressed memory port. The peripheral asks for a transfer by giving an address, a length in bytes, a direction and a bypass flag. The bridge forms the memory address by OR-ing the peripheral address with an upper-address register value, `hiAddr`. It then issues one or more memory commands and streams 16-bit beats between the two sides. Each side has its own valid/ready handshake.

In swapping mode the bridge drops bit 0 of the address and of the length. It then exchanges the two bytes of every halfword in both directions. Memory writes in this mode are cut into bursts of at most `BURST_BYTES`, and the address advances by the length of each burst. In bypass mode the address, the length and the data pass through untouched, and the whole request goes out as a single command. A `done` pulse ends every request. A request whose length is zero after alignment finishes with no memory command.

Top module: `hswap_dma_bridge`

## Requirements
- R1: The address of the first memory command equals `reqAddr | hiAddr`. Bit 0 of this value is cleared when `reqBypass` is 0.
- R2: With `reqBypass`=1, the command address and length are not aligned, and data beats pass unchanged in both directions.
- R3: With `reqBypass`=0, bit 0 of the effective length is cleared, and every command carries an even address and an even length.
- R4: With `reqBypass`=0 on a write (`reqWrite`=1), each memory write beat is the peripheral beat with bits [7:0] and [15:8] exchanged.
- R5: With `reqBypass`=0 on a read (`reqWrite`=0), each beat returned to the peripheral is the memory beat with bits [7:0] and [15:8] exchanged.
- R6: Swapped writes are issued as successive commands of `min(remaining, BURST_BYTES)` bytes, with `BURST_BYTES`=64 by default. Each command address is the previous address plus the previous length.
- R7: Reads, and bypass writes, are issued as exactly one command covering the whole effective length. `cmdWrite` equals `reqWrite`.
- R8: A command of L bytes moves ceil(L/2) beats. A request with an effective length of zero issues no command and no beat, and it pulses `done` on the cycle after acceptance.
- R9: `reqReady` is high only while idle. `busy` stays high from the cycle after acceptance through the `done` cycle. `done` is a single-cycle pulse, and requests presented while busy are ignored.
- R10: After reset the bridge is idle: `reqReady`=1, and `busy`, `done`, `cmdValid`, `memWvalid` and `rdValid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hiAddr | input | AW | Upper-address register value, OR-ed into every address |
| reqValid | input | 1 | Peripheral request valid |
| reqReady | output | 1 | Bridge idle and able to accept a request |
| reqAddr | input | AW | Peripheral byte address |
| reqLen | input | LW | Request length in bytes |
| reqWrite | input | 1 | 1: peripheral to memory, 0: memory to peripheral |
| reqBypass | input | 1 | 1: no alignment and no byte swap |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse at the end of a request |
| cmdValid | output | 1 | Memory command valid |
| cmdReady | input | 1 | Memory accepts the command |
| cmdAddr | output | AW | Command byte address |
| cmdLen | output | LW | Command length in bytes |
| cmdWrite | output | 1 | Command direction |
| wrValid | input | 1 | Peripheral write beat valid |
| wrReady | output | 1 | Bridge takes the peripheral write beat |
| wrData | input | 16 | Peripheral write beat |
| memWvalid | output | 1 | Memory write beat valid |
| memWready | input | 1 | Memory takes the write beat |
| memWdata | output | 16 | Memory write beat |
| memRvalid | input | 1 | Memory read beat valid |
| memRready | output | 1 | Bridge takes the memory read beat |
| memRdata | input | 16 | Memory read beat |
| rdValid | output | 1 | Read beat valid toward the peripheral |
| rdReady | input | 1 | Peripheral takes the read beat |
| rdData | output | 16 | Read beat toward the peripheral |

## Verification
Two decisions fall in the same cycle: the handshake of the last beat of a burst, and the choice between starting the next burst command and finishing the request. The bench provokes this with swapped writes whose lengths sit just under, at and over multiples of 64 bytes. Random stalls on every ready and valid move that final beat to arbitrary cycles. The bench judges the result from the captured command list, meaning the addresses, lengths and count against a model that chunks the length independently. It also counts the beats and the `done` pulses, so that a dropped or doubled boundary beat is reported.

// File: rtl/hswap_pkg.sv
package hswap_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_DATA, ST_FIN} state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture a new request
    logic cmdFire;   // a burst command was taken
    logic beatFire;  // one data beat moved
  } strobes_t;

  function automatic logic [15:0] swapHalf(input logic [15:0] x);
    return {x[7:0], x[15:8]};
  endfunction
endpackage

// File: rtl/hswap_ctrl.sv
module hswap_ctrl
  import hswap_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     cmdReady,
  input  logic     beatHs,
  input  logic     effZero,
  input  logic     remZero,
  input  logic     lastBeat,
  output strobes_t stb,
  output logic     inData,
  output logic     cmdValid,
  output logic     reqReady,
  output logic     busy,
  output logic     done
);
  state_e state, stateNxt;

  always_comb begin
    stateNxt     = state;
    stb          = '0;
    case (state)
      ST_IDLE: if (reqValid) begin
        stb.load = 1'b1;
        stateNxt = effZero ? ST_FIN : ST_CMD;
      end
      ST_CMD: if (cmdReady) begin
        stb.cmdFire = 1'b1;
        stateNxt    = ST_DATA;
      end
      ST_DATA: if (beatHs) begin
        stb.beatFire = 1'b1;
        if (lastBeat) stateNxt = remZero ? ST_FIN : ST_CMD;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign inData   = (state == ST_DATA);
  assign cmdValid = (state == ST_CMD);
  assign reqReady = (state == ST_IDLE);
  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_FIN);
endmodule

// File: rtl/hswap_datapath.sv
module hswap_datapath
  import hswap_pkg::*;
#(
  parameter int AW          = 32,
  parameter int LW          = 16,
  parameter int BURST_BYTES = 64
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobes_t      stb,
  input  logic          inData,
  input  logic [AW-1:0] hiAddr,
  input  logic [AW-1:0] reqAddr,
  input  logic [LW-1:0] reqLen,
  input  logic          reqWrite,
  input  logic          reqBypass,
  output logic          effZero,
  output logic          remZero,
  output logic          lastBeat,
  output logic          beatHs,
  output logic [AW-1:0] cmdAddr,
  output logic [LW-1:0] cmdLen,
  output logic          cmdWrite,
  input  logic          wrValid,
  output logic          wrReady,
  input  logic [15:0]   wrData,
  output logic          memWvalid,
  input  logic          memWready,
  output logic [15:0]   memWdata,
  input  logic          memRvalid,
  output logic          memRready,
  input  logic [15:0]   memRdata,
  output logic          rdValid,
  input  logic          rdReady,
  output logic [15:0]   rdData
);
  localparam logic [LW-1:0] BURST_L  = LW'(BURST_BYTES);
  localparam logic [AW-1:0] ALIGN_AM = ~AW'(1);
  localparam logic [LW-1:0] ALIGN_LM = ~LW'(1);

  logic [AW-1:0] curAddr;
  logic [LW-1:0] remLen, beatsLeft, burstLen, effLen;
  logic [LW:0]   beatsCalc;
  logic          isWrite, isBypass;
  logic [AW-1:0] formAddr;

  // request formation
  assign formAddr = reqBypass ? (reqAddr | hiAddr) : ((reqAddr | hiAddr) & ALIGN_AM);
  assign effLen   = reqBypass ? reqLen : (reqLen & ALIGN_LM);
  assign effZero  = (effLen == '0);

  // only swapped writes are chunked
  assign burstLen  = (isWrite && !isBypass && remLen > BURST_L) ? BURST_L : remLen;
  assign beatsCalc = ({1'b0, burstLen} + (LW+1)'(1)) >> 1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr   <= '0;
      remLen    <= '0;
      beatsLeft <= '0;
      isWrite   <= 1'b0;
      isBypass  <= 1'b0;
    end else begin
      if (stb.load) begin
        curAddr  <= formAddr;
        remLen   <= effLen;
        isWrite  <= reqWrite;
        isBypass <= reqBypass;
      end
      if (stb.cmdFire) begin
        beatsLeft <= beatsCalc[LW-1:0];
        remLen    <= remLen - burstLen;
        curAddr   <= curAddr + AW'(burstLen);
      end
      if (stb.beatFire) beatsLeft <= beatsLeft - LW'(1);
    end
  end

  assign remZero  = (remLen == '0);
  assign lastBeat = (beatsLeft == LW'(1));
  assign cmdAddr  = curAddr;
  assign cmdLen   = burstLen;
  assign cmdWrite = isWrite;

  // beat steering and lane swap
  assign memWvalid = inData && isWrite && wrValid;
  assign wrReady   = inData && isWrite && memWready;
  assign rdValid   = inData && !isWrite && memRvalid;
  assign memRready = inData && !isWrite && rdReady;
  assign beatHs    = isWrite ? (memWvalid && memWready) : (rdValid && rdReady);
  assign memWdata  = isBypass ? wrData : swapHalf(wrData);
  assign rdData    = isBypass ? memRdata : swapHalf(memRdata);
endmodule

// File: rtl/hswap_dma_bridge.sv
module hswap_dma_bridge
  import hswap_pkg::*;
#(
  parameter int AW          = 32,
  parameter int LW          = 16,
  parameter int BURST_BYTES = 64
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] hiAddr,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic [AW-1:0] reqAddr,
  input  logic [LW-1:0] reqLen,
  input  logic          reqWrite,
  input  logic          reqBypass,
  output logic          busy,
  output logic          done,
  output logic          cmdValid,
  input  logic          cmdReady,
  output logic [AW-1:0] cmdAddr,
  output logic [LW-1:0] cmdLen,
  output logic          cmdWrite,
  input  logic          wrValid,
  output logic          wrReady,
  input  logic [15:0]   wrData,
  output logic          memWvalid,
  input  logic          memWready,
  output logic [15:0]   memWdata,
  input  logic          memRvalid,
  output logic          memRready,
  input  logic [15:0]   memRdata,
  output logic          rdValid,
  input  logic          rdReady,
  output logic [15:0]   rdData
);
  strobes_t stb;
  logic inData, effZero, remZero, lastBeat, beatHs;

  hswap_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .cmdReady(cmdReady),
    .beatHs(beatHs), .effZero(effZero), .remZero(remZero), .lastBeat(lastBeat),
    .stb(stb), .inData(inData), .cmdValid(cmdValid), .reqReady(reqReady),
    .busy(busy), .done(done)
  );

  hswap_datapath #(.AW(AW), .LW(LW), .BURST_BYTES(BURST_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .inData(inData), .hiAddr(hiAddr),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqWrite(reqWrite), .reqBypass(reqBypass),
    .effZero(effZero), .remZero(remZero), .lastBeat(lastBeat), .beatHs(beatHs),
    .cmdAddr(cmdAddr), .cmdLen(cmdLen), .cmdWrite(cmdWrite),
    .wrValid(wrValid), .wrReady(wrReady), .wrData(wrData),
    .memWvalid(memWvalid), .memWready(memWready), .memWdata(memWdata),
    .memRvalid(memRvalid), .memRready(memRready), .memRdata(memRdata),
    .rdValid(rdValid), .rdReady(rdReady), .rdData(rdData)
  );
endmodule

// File: rtl/hswap_dma_bridge_chk.sv
module hswap_dma_bridge_chk #(
  parameter int AW          = 32,
  parameter int LW          = 16,
  parameter int BURST_BYTES = 64
) (
  input logic          clk,
  input logic          rstN,
  input logic          reqValid,
  input logic          reqReady,
  input logic          reqBypass,
  input logic          busy,
  input logic          done,
  input logic          cmdValid,
  input logic          cmdReady,
  input logic [AW-1:0] cmdAddr,
  input logic [LW-1:0] cmdLen,
  input logic          cmdWrite,
  input logic [15:0]   wrData,
  input logic          memWvalid,
  input logic [15:0]   memWdata,
  input logic          rdValid,
  input logic [15:0]   rdData,
  input logic [15:0]   memRdata
);
  logic bypassQ;
  always_ff @(posedge clk) begin
    if (!rstN) bypassQ <= 1'b0;
    else if (reqValid && reqReady) bypassQ <= reqBypass;
  end

  // R9
  accept_sets_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> busy);
  // R9
  done_ends_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy && !done);
  // R6
  cmd_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> cmdValid && $stable(cmdAddr) && $stable(cmdLen));
  // R8
  cmd_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> cmdLen != '0);
  // R3
  cmd_even_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !bypassQ |-> !cmdAddr[0] && !cmdLen[0]);
  // R6
  burst_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdWrite && !bypassQ |-> cmdLen <= LW'(BURST_BYTES));
  // R4
  wr_swap_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWvalid && !bypassQ |-> memWdata == {wrData[7:0], wrData[15:8]});
  // R5
  rd_swap_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && !bypassQ |-> rdData == {memRdata[7:0], memRdata[15:8]});
  // R2
  rd_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && bypassQ |-> rdData == memRdata);
endmodule

bind hswap_dma_bridge hswap_dma_bridge_chk #(.AW(AW), .LW(LW), .BURST_BYTES(BURST_BYTES)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqBypass(reqBypass),
  .busy(busy), .done(done), .cmdValid(cmdValid), .cmdReady(cmdReady),
  .cmdAddr(cmdAddr), .cmdLen(cmdLen), .cmdWrite(cmdWrite), .wrData(wrData),
  .memWvalid(memWvalid), .memWdata(memWdata), .rdValid(rdValid), .rdData(rdData),
  .memRdata(memRdata)
);

// File: tb/hswap_dma_bridge_bench.sv
module hswap_dma_bridge_bench;
  localparam int AW = 32, LW = 16, BB = 64;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN;
  logic [AW-1:0] hiAddr, reqAddr, cmdAddr;
  logic [LW-1:0] reqLen, cmdLen;
  logic reqValid, reqReady, reqWrite, reqBypass, busy, done;
  logic cmdValid, cmdReady, cmdWrite;
  logic wrValid, wrReady, memWvalid, memWready, memRvalid, memRready, rdValid, rdReady;
  logic [15:0] wrData, memWdata, memRdata, rdData;

  hswap_dma_bridge #(.AW(AW), .LW(LW), .BURST_BYTES(BB)) u_hswap_dma_bridge (
    .clk(clk), .rstN(rstN), .hiAddr(hiAddr), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqWrite(reqWrite), .reqBypass(reqBypass),
    .busy(busy), .done(done), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdAddr(cmdAddr), .cmdLen(cmdLen), .cmdWrite(cmdWrite),
    .wrValid(wrValid), .wrReady(wrReady), .wrData(wrData),
    .memWvalid(memWvalid), .memWready(memWready), .memWdata(memWdata),
    .memRvalid(memRvalid), .memRready(memRready), .memRdata(memRdata),
    .rdValid(rdValid), .rdReady(rdReady), .rdData(rdData)
  );

  int nChk = 0;
  int nBad = 0;

  function automatic logic [15:0] pat(input int i, input int s);
    return 16'(i * 16'h0F1D + s * 16'h2B) ^ 16'hA55A;
  endfunction

  function automatic logic [15:0] swp(input logic [15:0] x);
    return {x[7:0], x[15:8]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic runReq(input logic [31:0] a, input int l, input bit w,
                        input bit byp, input logic [31:0] hi);
    logic [31:0] eA[8];
    int eL[8];
    int nE = 0, totB = 0, effL, left, nC = 0, wI = 0, rI = 0, busyBad = 0;
    bit dn = 0;
    logic [31:0] base;
    logic [15:0] ex;
    base = byp ? (a | hi) : ((a | hi) & 32'hFFFF_FFFE);
    effL = byp ? l : (l & 32'hFFFE);
    left = effL;
    while (left > 0 && nE < 8) begin
      int c;
      c = (w && !byp && left > BB) ? BB : left;
      eA[nE] = base; eL[nE] = c;
      base += 32'(c); totB += (c + 1) / 2; left -= c; nE++;
    end
    hiAddr = hi;
    for (int k = 0; k < 4000 && !dn; k++) begin
      @(negedge clk);
      if (k == 0) begin
        reqValid = 1'b1; reqAddr = a; reqLen = 16'(l); reqWrite = w; reqBypass = byp;
      end else begin
        // R9: garbage requests while busy must be ignored
        reqValid = 1'b1; reqAddr = $urandom; reqLen = 16'($urandom);
        reqWrite = 1'($urandom); reqBypass = 1'($urandom);
      end
      cmdReady  = ($urandom % 3) != 0;
      wrValid   = ($urandom % 4) != 0;
      wrData    = pat(wI, 0);
      memWready = ($urandom % 3) != 0;
      memRvalid = ($urandom % 4) != 0;
      memRdata  = pat(rI, 1);
      rdReady   = ($urandom % 3) != 0;
      #1;
      if (k == 0) chk(reqReady == 1'b1, "R9", "ready while idle", longint'(reqReady), 1);
      else if (!done && (!busy || reqReady)) busyBad++;
      if (cmdValid && cmdReady) begin
        if (nC < nE) begin
          chk(cmdAddr == eA[nC], (nC == 0) ? "R1" : "R6", "command address", cmdAddr, eA[nC]);
          chk(int'(cmdLen) == eL[nC], byp ? "R2" : ((w) ? "R6" : "R3"), "command length",
              cmdLen, eL[nC]);
          chk(cmdWrite == w, "R7", "command direction", cmdWrite, w);
        end
        nC++;
      end
      if (memWvalid && memWready) begin
        ex = byp ? pat(wI, 0) : swp(pat(wI, 0));
        chk(wrValid && wrReady, "R4", "source beat taken", longint'(wrReady), 1);
        chk(memWdata == ex, byp ? "R2" : "R4", "write beat", memWdata, ex);
        wI++;
      end
      if (rdValid && rdReady) begin
        ex = byp ? pat(rI, 1) : swp(pat(rI, 1));
        chk(memRvalid && memRready, "R5", "memory beat taken", longint'(memRready), 1);
        chk(rdData == ex, byp ? "R2" : "R5", "read beat", rdData, ex);
        rI++;
      end
      if (done) begin
        dn = 1'b1;
        reqValid = 1'b0;
      end
    end
    chk(nC == nE, (effL == 0) ? "R8" : ((w && !byp) ? "R6" : "R7"), "command count", nC, nE);
    chk((w ? wI : rI) == totB, "R8", "beat count", w ? wI : rI, totB);
    chk((w ? rI : wI) == 0, "R8", "beats on idle path", w ? rI : wI, 0);
    chk(dn, "R9", "done seen", longint'(dn), 1);
    chk(busyBad == 0, "R9", "busy/ready while active", busyBad, 0);
    @(negedge clk); #1;
    chk(!busy && reqReady && !done, "R9", "idle after done", {busy, reqReady, done}, 3'b010);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChk + 1, nBad + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b0; hiAddr = '0; reqValid = 1'b0; reqAddr = '0; reqLen = '0;
    reqWrite = 1'b0; reqBypass = 1'b0; cmdReady = 1'b0; wrValid = 1'b0; wrData = '0;
    memWready = 1'b0; memRvalid = 1'b0; memRdata = '0; rdReady = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    // R10 reset state
    chk(reqReady && !busy && !done && !cmdValid && !memWvalid && !rdValid, "R10",
        "reset state", {reqReady, busy, done, cmdValid, memWvalid, rdValid}, 6'b100000);
    rstN = 1'b1;
    // directed corners
    runReq(32'h0000_1001, 0,   1, 0, 32'h4000_0000); // R8 zero
    runReq(32'h0000_1001, 1,   1, 0, 32'h4000_0000); // R8 aligns to zero
    runReq(32'h0000_2003, 1,   1, 1, 32'h0000_0000); // R2 single odd byte
    runReq(32'h0000_3005, 7,   0, 1, 32'h0100_0000); // R2 odd read
    runReq(32'h0000_0011, 64,  1, 0, 32'h8000_0010); // R6 exactly one burst
    runReq(32'h0000_0100, 65,  1, 0, 32'h0000_0000); // R3/R6 65 -> 64
    runReq(32'h0000_0100, 66,  1, 0, 32'h0000_0000); // R6 64 + 2
    runReq(32'h0000_0201, 131, 1, 0, 32'h2000_0003); // R1/R6 64+64+2
    runReq(32'h0000_0400, 200, 0, 0, 32'h0000_0000); // R5/R7 long read
    runReq(32'h0000_0500, 150, 1, 1, 32'h0000_0000); // R7 bypass write, one command
    // random mix
    for (int t = 0; t < 40; t++)
      runReq($urandom, int'($urandom % 301), 1'($urandom), ($urandom % 4) == 0, $urandom);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule